// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block turns the decisions of a flash converter's comparator bank into a binary code. The bank delivers a word of 2^N-1 bits. Bit i is 1 when the analog input lies above the i-th reference, so an ideal word is a run of ones that starts at bit 0 and ends at the code boundary. The encoder does not look for that boundary. It counts the ones in the word. A bubble is a stray 0 inside the run of ones or a stray 1 above it. With counting, a bubble moves the result by at most one step, where a boundary detector could produce a code that is far off.

The ones are summed in a tree of 3:2 carry-save compressors. The tree reduces the word to two rows, and a single carry-propagate adder adds them. The comparator word is captured on one clock edge, and the count is registered on the next edge, so the latency is a fixed two cycles and a new word can be accepted every cycle. A flag that comes out alongside each code reports whether the word that produced it was a clean thermometer code. The resolution N is a parameter in the range 1 to 6 and defaults to 3.

Top module: `therm_bin_enc`

## Requirements
- R1: A word on `therm_in` is sampled at a rising edge of `clk`. Its code and flag appear on `code` and `bubble` after the following rising edge. The total latency is two cycles.
- R2: `code` equals the number of 1 bits in the sampled word, where bit i of `therm_in` is the decision of comparator i and bit 0 belongs to the lowest reference.
- R3: A clean word whose bits 0 to k-1 are 1 and whose other bits are 0 gives `code` = k. This covers the all-zero word (code 0) and the all-ones word (code 2^N-1).
- R4: A word that differs from a clean word of k ones in a single bit gives a code that is within one step of k.
- R5: `bubble` is 1 exactly when the sampled word holds a 1 at some bit index whose lower-indexed neighbour is 0, that is, when the word is not of the form 2^k-1. It is aligned with the code of the same word.
- R6: While `rst` is high at a rising edge, the input register, `code` and `bubble` are cleared. After `rst` is released, outputs stay 0 until the first newly sampled word reaches them.
- R7: Words applied on consecutive cycles each produce their own code and flag, one per cycle, in order and with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| therm_in | input | 2^N-1 | Comparator decisions, bit 0 = lowest reference |
| code | output | N | Registered count of ones |
| bubble | output | 1 | Registered flag: the word was not a clean thermometer code |

## Verification
The in-line properties assume that reset is asserted on the first clock edge and that `therm_in` is settled at every rising edge. Under those conditions, the value a property looks back on was always sampled after reset. The bench drives inputs only at falling edges and holds reset high from time zero. It then streams every one of the 128 possible 7-bit words back to back, without restricting them to clean codes. Both the properties and the bench's arithmetic model therefore see every bubble pattern, including words that are nothing but bubbles.

// File: rtl/therm_enc_pkg.sv
package therm_enc_pkg;

   // Number of rows left after l levels of 3:2 compression of n rows.
   function automatic int csa_rows_after(input int n, input int l);
      int c;
      c = n;
      for (int i = 0; i < l; i++) begin
         if (c > 2) c = 2 * (c / 3) + (c % 3);
      end
      return c;
   endfunction

   // Number of 3:2 levels needed to reach at most two rows.
   function automatic int csa_depth(input int n);
      int c;
      int l;
      c = n;
      l = 0;
      for (int i = 0; i < 32; i++) begin
         if (c > 2) begin
            c = 2 * (c / 3) + (c % 3);
            l = l + 1;
         end
      end
      return l;
   endfunction

endpackage

// File: rtl/csa_cell.sv
// One word-wide 3:2 compressor: three addends in, sum row and carry row out.
module csa_cell #(
   parameter int W = 3
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] c,
   output logic [W-1:0] s,
   output logic [W-1:0] k
);
   logic [W-1:0] maj;

   assign s   = a ^ b ^ c;
   assign maj = (a & b) | (a & c) | (b & c);
   assign k   = maj << 1;
endmodule

// File: rtl/ones_csa_tree.sv
// Population count of a bit vector through a tree of 3:2 compressors
// followed by one carry-propagate adder.
module ones_csa_tree
   import therm_enc_pkg::*;
#(
   parameter int NIN = 7,
   parameter int OW  = 3
) (
   input  logic [NIN-1:0] bits,
   output logic [OW-1:0]  total
);
   localparam int LV = csa_depth(NIN);
   localparam int CF = csa_rows_after(NIN, LV);

   logic [OW-1:0] row [0:LV][0:NIN-1];

   for (genvar i = 0; i < NIN; i++) begin : g_seed
      assign row[0][i] = OW'(bits[i]);
   end

   for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
      localparam int CIN  = csa_rows_after(NIN, lv);
      localparam int GRP  = CIN / 3;
      localparam int REM  = CIN % 3;
      localparam int COUT = 2 * GRP + REM;

      for (genvar g = 0; g < GRP; g++) begin : g_cmp
         csa_cell #(.W(OW)) u_cell (
            .a(row[lv][3*g]),
            .b(row[lv][3*g+1]),
            .c(row[lv][3*g+2]),
            .s(row[lv+1][2*g]),
            .k(row[lv+1][2*g+1])
         );
      end
      for (genvar r = 0; r < REM; r++) begin : g_pass
         assign row[lv+1][2*GRP+r] = row[lv][3*GRP+r];
      end
      for (genvar z = COUT; z < NIN; z++) begin : g_zero
         assign row[lv+1][z] = '0;
      end
   end

   if (CF >= 2) begin : g_cpa
      assign total = row[LV][0] + row[LV][1];
   end else begin : g_single
      assign total = row[LV][0];
   end
endmodule

// File: rtl/bubble_detect.sv
// Flags any 0-to-1 step going upward through the word.
module bubble_detect #(
   parameter int W = 7
) (
   input  logic [W-1:0] t,
   output logic         flag
);
   if (W > 1) begin : g_scan
      logic [W-1:1] step;
      for (genvar i = 1; i < W; i++) begin : g_bit
         assign step[i] = t[i] & ~t[i-1];
      end
      assign flag = |step;
   end else begin : g_none
      assign flag = 1'b0;
   end
endmodule

// File: rtl/therm_in_reg.sv
module therm_in_reg #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
   end
endmodule

// File: rtl/therm_bin_enc.sv
module therm_bin_enc #(
   parameter  int N   = 3,
   localparam int NIN = (1 << N) - 1
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [NIN-1:0] therm_in,
   output logic [N-1:0]   code,
   output logic           bubble
);
   if (N < 1 || N > 6) begin : g_bad_n
      $error("therm_bin_enc: N must lie in 1..6");
   end

   logic [NIN-1:0] therm_q;
   logic [N-1:0]   count;
   logic           flag;

   therm_in_reg #(.W(NIN)) u_inreg (
      .clk(clk), .rst(rst), .d(therm_in), .q(therm_q)
   );

   ones_csa_tree #(.NIN(NIN), .OW(N)) u_tree (
      .bits(therm_q), .total(count)
   );

   bubble_detect #(.W(NIN)) u_bub (
      .t(therm_q), .flag(flag)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         code   <= '0;
         bubble <= 1'b0;
      end else begin
         code   <= count;
         bubble <= flag;
      end
   end

   // R2: registered code is the ones count of the previously captured word
   a_r2_count: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> code == N'($countones($past(therm_q))));

   // R5: flag set exactly when the captured word is not of form 2^k-1
   a_r5_flag: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> bubble == (($past(therm_q) & ($past(therm_q) + 1'b1)) != '0));

   // R6: a reset edge leaves code and flag clear
   a_r6_reset_clear: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (code == '0 && !bubble));

   // R3: full-scale word maps to the top code with no flag
   a_r3_full_scale: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (&$past(therm_q))) |-> (&code && !bubble));

   // R1: the code follows the raw input two edges later
   a_r1_latency: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> code == N'($countones($past(therm_in, 2))));
endmodule

// File: tb/therm_bin_enc_bench.sv
module therm_bin_enc_bench;
   localparam int N   = 3;
   localparam int NIN = 7;

   logic           clk = 1'b0;
   logic           rst = 1'b1;
   logic [NIN-1:0] therm_in = '0;
   logic [N-1:0]   code;
   logic           bubble;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   therm_bin_enc #(.N(N)) u_therm_bin_enc (
      .clk(clk), .rst(rst), .therm_in(therm_in), .code(code), .bubble(bubble)
   );

   function automatic int ones(input logic [NIN-1:0] w);
      int c = 0;
      for (int i = 0; i < NIN; i++) c += int'(w[i]);
      return c;
   endfunction

   function automatic logic is_bad(input logic [NIN-1:0] w);
      logic [NIN-1:0] p;
      p = w + 1'b1;
      return (w & p) != '0;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   logic [NIN-1:0] hist [0:1];

   initial begin : watchdog
      #400000;
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R6: reset state
      chk("R6 code in reset", int'(code), 0);
      chk("R6 flag in reset", int'(bubble), 0);
      therm_in = 7'h7f;
      @(negedge clk);
      rst = 1'b0;
      therm_in = 7'h00;
      // R6: the register was cleared, so nothing appears until a new sample arrives
      @(negedge clk);
      chk("R6 code after release", int'(code), 0);
      chk("R6 flag after release", int'(bubble), 0);

      // R1 R2 R5 R7: stream all words back to back, checking two cycles later
      for (int i = 0; i < 130; i++) begin
         if (i >= 2) begin
            chk("R2 R7 stream code", int'(code), ones(hist[0]));
            chk("R5 stream flag", int'(bubble), int'(is_bad(hist[0])));
         end
         hist[0] = hist[1];
         hist[1] = NIN'(i);
         therm_in = NIN'(i);
         @(negedge clk);
      end

      // R1: a single word, isolated, arrives after exactly two edges
      therm_in = 7'h00;
      repeat (2) @(negedge clk);
      therm_in = 7'h0f;
      @(negedge clk);
      therm_in = 7'h00;
      chk("R1 not yet after one edge", int'(code), 0);
      @(negedge clk);
      chk("R1 after two edges", int'(code), 4);
      @(negedge clk);
      chk("R1 next word follows", int'(code), 0);

      // R3: every clean word, including zero and full scale
      for (int k = 0; k <= NIN; k++) begin
         therm_in = NIN'((1 << k) - 1);
         repeat (2) @(negedge clk);
         chk("R3 clean code", int'(code), k);
         chk("R5 clean no flag", int'(bubble), 0);
      end

      // R4: single-bit upsets of clean words stay within one step
      for (int k = 0; k <= NIN; k++) begin
         for (int b = 0; b < NIN; b++) begin
            int d;
            therm_in = NIN'((1 << k) - 1) ^ NIN'(1 << b);
            repeat (2) @(negedge clk);
            d = int'(code) - k;
            chk("R4 bubble within one step", (d <= 1 && d >= -1) ? 1 : 0, 1);
         end
      end

      // R6: reset mid-stream clears outputs
      therm_in = 7'h35;
      repeat (2) @(negedge clk);
      chk("R5 flag before reset", int'(bubble), 1);
      rst = 1'b1;
      @(negedge clk);
      chk("R6 code cleared", int'(code), 0);
      chk("R6 flag cleared", int'(bubble), 0);
      rst = 1'b0;
      therm_in = 7'h07;
      repeat (2) @(negedge clk);
      chk("R6 resumes after reset", int'(code), 3);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule